// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A request carries the virtual address and the base of the first-level table. The walker reads one first-level word, decodes its 2-bit type, and either finishes at once or reads one second-level word and decodes that. A first-level entry can be a fault, a 1 MB section, a 16 MB supersection, or a pointer to a second-level table. A 1 KB coarse table is indexed by VA[19:12]. A 4 KB fine table is indexed by VA[19:10].

The result returns as a one-cycle completion pulse. It carries the physical address, a page-size code, the 4-bit domain from the first-level entry and a 2-bit permission. When the walk fails, it carries a fault code instead, which names the level where the walk failed. The memory port issues one-cycle read strobes and accepts a response after any number of cycles. Only one walk is in flight at a time, and the walker returns to idle after each completion.

Top module: `tt_walker`

## Requirements
- R1: `req_ready` is high only while idle. A request is accepted on `req_valid && req_ready`. Each accepted request gives exactly one one-cycle `done_valid` pulse, and `req_ready` is high again in the cycle after that pulse.
- R2: In the cycle after acceptance, `mem_rd_req` pulses for one cycle with address {base[31:14], VA[31:20], 2'b00}.
- R3: If first-level bits [1:0] = 00, the walk completes with `done_fault` = 2'b01, with pa, size, domain and perm all zero, and with no second read.
- R4: If first-level type = 10 and bit 18 = 0, the walk completes with pa = {d[31:20], VA[19:0]}, size code 4, domain = d[8:5] and perm = d[11:10].
- R5: If first-level type = 10 and bit 18 = 1, the walk completes with pa = {d[31:24], VA[23:0]}, size code 5, domain = d[8:5] and perm = d[11:10].
- R6: First-level type 01 (coarse) causes a second read at {d[31:10], VA[19:12], 2'b00}. Type 11 (fine) causes a second read at {d[31:12], VA[19:10], 2'b00}.
- R7: Second-level type 00 in either kind of table, and type 11 in a coarse table, complete with `done_fault` = 2'b10 and pa, size, domain and perm all zero.
- R8: Second-level type 01 (large page) gives pa = {e[31:16], VA[15:0]} and size code 3. Its perm is the field of e picked by VA[15:14]: 0→[5:4], 1→[7:6], 2→[9:8], 3→[11:10].
- R9: Second-level type 10 (small page) gives pa = {e[31:12], VA[11:0]} and size code 2. Its perm is picked by VA[11:10] with the same mapping as in R8.
- R10: Second-level type 11 in a fine table (tiny page) gives pa = {e[31:10], VA[9:0]}, size code 1 and perm = e[5:4]. For any second-level page, domain is the first-level d[8:5].
- R11: A read response is used only while a read is outstanding. `mem_rsp_valid` while idle has no effect on the outputs, and a response may arrive any number of cycles after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_base | input | 32 | First-level table base (bits [31:14] used) |
| mem_rd_req | output | 1 | One-cycle word read strobe |
| mem_rd_addr | output | 32 | Word read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read descriptor word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Physical address |
| done_size | output | 3 | Size code: 0 none, 1 1K, 2 4K, 3 64K, 4 1M, 5 16M |
| done_domain | output | 4 | Domain from the first-level entry |
| done_perm | output | 2 | Access permission field |
| done_fault | output | 2 | bit0 first-level fault, bit1 second-level fault |

## Verification
The embedded assertions check the handshake on every cycle. They confirm that a completion is followed by idle, that read strobes last one cycle, that the first read follows acceptance at the right address, and that a faulting completion carries a single fault bit with a zeroed address. The per-type address formation, the choice of subpage permission and the indexing of each table kind can only be shown by the bench. It drives directed and random descriptors through a memory model with random latency and compares every completion against its own expected values.

// File: rtl/tt_pkg.sv
// Shared types for the two-level table walker.
// Assumes 32-bit addresses and descriptors with fixed field positions.
package tt_pkg;
    localparam int VA_W   = 32;
    localparam int DOM_W  = 4;
    localparam int AP_W   = 2;
    localparam int FLT_W  = 2;
    localparam int SUBPG  = 4;

    localparam logic [FLT_W-1:0] FLT_NONE = 2'b00;
    localparam logic [FLT_W-1:0] FLT_LVL1 = 2'b01;
    localparam logic [FLT_W-1:0] FLT_LVL2 = 2'b10;

    typedef enum logic [2:0] {
        SZ_NONE = 3'd0,
        SZ_1K   = 3'd1,
        SZ_4K   = 3'd2,
        SZ_64K  = 3'd3,
        SZ_1M   = 3'd4,
        SZ_16M  = 3'd5
    } pg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_RD, ST_L1_WT, ST_L2_RD, ST_L2_WT, ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [VA_W-1:0]  pa;
        pg_size_e         size;
        logic [DOM_W-1:0] domain;
        logic [AP_W-1:0]  perm;
        logic [FLT_W-1:0] fault;
    } walk_res_t;
endpackage

// File: rtl/tt_l1_decode.sv
// First-level descriptor decoder (combinational).
// Resolves faults, sections and supersections into a final result, or
// forms the second-level entry address for coarse and fine tables.
module tt_l1_decode
    import tt_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] desc,
    output logic            leaf,
    output walk_res_t       res,
    output logic [VA_W-1:0] next_addr,
    output logic            next_fine
);
    // Decode the 2-bit type and build the leaf result or the next address.
    always_comb begin
        res       = '0;
        leaf      = 1'b1;
        next_addr = '0;
        next_fine = 1'b0;
        unique case (desc[1:0])
            2'b00: res.fault = FLT_LVL1;
            2'b10: begin
                res.domain = desc[8:5];
                res.perm   = desc[11:10];
                if (desc[18]) begin
                    res.pa   = {desc[31:24], va[23:0]};
                    res.size = SZ_16M;
                end else begin
                    res.pa   = {desc[31:20], va[19:0]};
                    res.size = SZ_1M;
                end
            end
            2'b01: begin
                leaf      = 1'b0;
                next_addr = {desc[31:10], va[19:12], 2'b00};
            end
            default: begin
                leaf      = 1'b0;
                next_fine = 1'b1;
                next_addr = {desc[31:12], va[19:10], 2'b00};
            end
        endcase
    end
endmodule

// File: rtl/tt_l2_decode.sv
// Second-level descriptor decoder (combinational).
// Assumes the caller says whether the entry came from a fine table and
// supplies the domain captured from the first-level entry.
module tt_l2_decode
    import tt_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [VA_W-1:0]  desc,
    input  logic             fine,
    input  logic [DOM_W-1:0] domain,
    output walk_res_t        res
);
    logic [AP_W-1:0] sub_ap [SUBPG];

    // One permission field per quarter of a large or small page.
    for (genvar g = 0; g < SUBPG; g++) begin : g_ap
        assign sub_ap[g] = desc[4 + AP_W*g +: AP_W];
    end

    // Decode the page type into address, size and permission.
    always_comb begin
        res = '0;
        unique case (desc[1:0])
            2'b01: begin
                res.pa     = {desc[31:16], va[15:0]};
                res.size   = SZ_64K;
                res.perm   = sub_ap[va[15:14]];
                res.domain = domain;
            end
            2'b10: begin
                res.pa     = {desc[31:12], va[11:0]};
                res.size   = SZ_4K;
                res.perm   = sub_ap[va[11:10]];
                res.domain = domain;
            end
            2'b11: begin
                if (fine) begin
                    res.pa     = {desc[31:10], va[9:0]};
                    res.size   = SZ_1K;
                    res.perm   = sub_ap[0];
                    res.domain = domain;
                end else begin
                    res.fault = FLT_LVL2;
                end
            end
            default: res.fault = FLT_LVL2;
        endcase
    end
endmodule

// File: rtl/tt_walker.sv
// Two-level translation table walker, top level.
// Accepts one request at a time, issues one-cycle read strobes and waits
// for a variable-latency response. The memory must answer each strobe once.
module tt_walker
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [VA_W-1:0]   req_base,
    output logic              mem_rd_req,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              done_valid,
    output logic [VA_W-1:0]   done_pa,
    output logic [2:0]        done_size,
    output logic [DOM_W-1:0]  done_domain,
    output logic [AP_W-1:0]   done_perm,
    output logic [FLT_W-1:0]  done_fault
);
    walk_st_e         state;
    logic [VA_W-1:0]  va_q, base_q, l2_addr_q;
    logic             fine_q;
    logic [DOM_W-1:0] dom_q;
    walk_res_t        res_q;

    logic             l1_leaf, l1_fine;
    walk_res_t        l1_res, l2_res;
    logic [VA_W-1:0]  l1_next;

    tt_l1_decode u_l1 (
        .va(va_q), .desc(mem_rsp_data), .leaf(l1_leaf), .res(l1_res),
        .next_addr(l1_next), .next_fine(l1_fine)
    );

    tt_l2_decode u_l2 (
        .va(va_q), .desc(mem_rsp_data), .fine(fine_q), .domain(dom_q),
        .res(l2_res)
    );

    // Sequence the walk through its fetch and wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            base_q    <= '0;
            l2_addr_q <= '0;
            fine_q    <= 1'b0;
            dom_q     <= '0;
            res_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    base_q <= req_base;
                    state  <= ST_L1_RD;
                end
                ST_L1_RD: state <= ST_L1_WT;
                ST_L1_WT: if (mem_rsp_valid) begin
                    if (l1_leaf) begin
                        res_q <= l1_res;
                        state <= ST_DONE;
                    end else begin
                        l2_addr_q <= l1_next;
                        fine_q    <= l1_fine;
                        dom_q     <= mem_rsp_data[8:5];
                        state     <= ST_L2_RD;
                    end
                end
                ST_L2_RD: state <= ST_L2_WT;
                ST_L2_WT: if (mem_rsp_valid) begin
                    res_q <= l2_res;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the port outputs from state and captured results.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_rd_req  = (state == ST_L1_RD) || (state == ST_L2_RD);
        mem_rd_addr = (state == ST_L2_RD) ? l2_addr_q
                                          : {base_q[31:14], va_q[31:20], 2'b00};
        done_valid  = (state == ST_DONE);
        done_pa     = res_q.pa;
        done_size   = res_q.size;
        done_domain = res_q.domain;
        done_perm   = res_q.perm;
        done_fault  = res_q.fault;
    end

    // R1: a completion is a single pulse followed by idle.
    a_r1_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (req_ready && !done_valid));

    // R1: no request is accepted while a read is being issued.
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    // R2: first read follows acceptance at the first-level entry address.
    a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_req &&
            mem_rd_addr == {$past(req_base[31:14]), $past(req_va[31:20]), 2'b00}));

    // R11: read strobes last one cycle.
    a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R3: a completion names at most one faulting level.
    a_r3_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $onehot0(done_fault));

    // R7: a faulting completion carries no address or size.
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault != 2'b00) |-> (done_pa == '0 && done_size == 3'd0));
endmodule

// File: tb/tt_walker_bench.sv
module tt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0, req_base = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_pa;
    logic [2:0]  done_size;
    logic [3:0]  done_domain;
    logic [1:0]  done_perm, done_fault;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tt_walker u_tt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_pa(done_pa),
        .done_size(done_size), .done_domain(done_domain), .done_perm(done_perm),
        .done_fault(done_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] pick_ap(input logic [31:0] e, input logic [1:0] q);
        case (q)
            2'd0: return e[5:4];
            2'd1: return e[7:6];
            2'd2: return e[9:8];
            default: return e[11:10];
        endcase
    endfunction

    // Expected outcome of a walk, from the requirements.
    task automatic model(input logic [31:0] va, base, d, e,
                         output int nrd, output logic [31:0] a1, a2, pa,
                         output logic [2:0] sz, output logic [3:0] dom,
                         output logic [1:0] ap, flt, output string tag);
        nrd = 1; a2 = '0; pa = '0; sz = 3'd0; dom = '0; ap = '0; flt = 2'b00;
        a1 = {base[31:14], va[31:20], 2'b00};
        tag = "R3";
        if (d[1:0] == 2'b00) flt = 2'b01;
        else if (d[1:0] == 2'b10) begin
            dom = d[8:5]; ap = d[11:10];
            if (d[18]) begin pa = {d[31:24], va[23:0]}; sz = 3'd5; tag = "R5"; end
            else       begin pa = {d[31:20], va[19:0]}; sz = 3'd4; tag = "R4"; end
        end else begin
            nrd = 2;
            if (d[1:0] == 2'b01) a2 = {d[31:10], va[19:12], 2'b00};
            else                 a2 = {d[31:12], va[19:10], 2'b00};
            case (e[1:0])
                2'b00: begin flt = 2'b10; tag = "R7"; end
                2'b01: begin pa = {e[31:16], va[15:0]}; sz = 3'd3;
                             ap = pick_ap(e, va[15:14]); dom = d[8:5]; tag = "R8"; end
                2'b10: begin pa = {e[31:12], va[11:0]}; sz = 3'd2;
                             ap = pick_ap(e, va[11:10]); dom = d[8:5]; tag = "R9"; end
                default: begin
                    if (d[1:0] == 2'b11) begin
                        pa = {e[31:10], va[9:0]}; sz = 3'd1; ap = e[5:4];
                        dom = d[8:5]; tag = "R10";
                    end else begin flt = 2'b10; tag = "R7"; end
                end
            endcase
        end
    endtask

    // Run one walk, serving reads with the given latency, and check it.
    task automatic walk(input logic [31:0] va, base, d, e, input int lat);
        int nrd, seen, guard;
        logic [31:0] a1, a2, pa;
        logic [2:0] sz;
        logic [3:0] dom;
        logic [1:0] ap, flt;
        string tag;
        bit fin;
        model(va, base, d, e, nrd, a1, a2, pa, sz, dom, ap, flt, tag);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_va = va; req_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", {31'd0, req_ready}, 32'd0);
        seen = 0; guard = 0; fin = 0;
        while (!fin && guard < 100) begin
            guard++;
            if (done_valid) begin
                chk(seen == nrd, {tag, " read count"}, seen, nrd);
                chk(done_fault == flt, {tag, " fault"}, {30'd0, done_fault}, {30'd0, flt});
                chk(done_pa == pa, {tag, " pa"}, done_pa, pa);
                chk(done_size == sz, {tag, " size"}, {29'd0, done_size}, {29'd0, sz});
                chk(done_domain == dom, {tag, " domain"}, {28'd0, done_domain}, {28'd0, dom});
                chk(done_perm == ap, {tag, " perm"}, {30'd0, done_perm}, {30'd0, ap});
                fin = 1;
                @(negedge clk);
                chk(!done_valid && req_ready, "R1 single done then idle",
                    {30'd0, done_valid, req_ready}, 32'd1);
            end else if (mem_rd_req) begin
                seen++;
                if (seen == 1) chk(mem_rd_addr == a1, "R2 first read addr", mem_rd_addr, a1);
                else           chk(mem_rd_addr == a2, "R6 second read addr", mem_rd_addr, a2);
                @(negedge clk);
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = (seen == 1) ? d : e;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = $urandom;
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) chk(1'b0, "R1 walk completes", 32'd0, 32'd1);
    endtask

    initial begin
        #1200000;
        chk(1'b0, "R1 watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !done_valid && !mem_rd_req, "R1 reset state",
            {29'd0, req_ready, done_valid, mem_rd_req}, 32'd4);

        // R11: a stray response while idle has no effect
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h1234_5672;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(!done_valid && req_ready && !mem_rd_req, "R11 stray response ignored",
            {29'd0, req_ready, done_valid, mem_rd_req}, 32'd4);

        // Directed corner cases
        walk(32'hABCD_1234, 32'h8000_4000, 32'h0000_0000, 32'h0, 0);          // R3
        walk(32'h1234_5678, 32'h0001_C000, 32'hFED0_0DE2, 32'h0, 1);          // R4
        walk(32'h1234_5678, 32'h0001_C000, 32'hFE04_0962, 32'h0, 2);          // R5
        for (int q = 0; q < 4; q++)                                           // R8
            walk({16'h5A5A, q[1:0], 14'h0123}, 32'h4000_0000, 32'h0012_3421,
                 32'hBEEF_0E45, q);
        for (int q = 0; q < 4; q++)                                           // R9
            walk({20'hCAFE1, q[1:0], 10'h155}, 32'h4000_0000, 32'h0012_3401,
                 32'h7777_7396, 0);
        walk(32'h0003_0000, 32'h0, 32'h1111_1001, 32'h2222_2223, 3);          // R7 coarse 11
        walk(32'h0003_0000, 32'h0, 32'h1111_1001, 32'h2222_2220, 0);          // R7 coarse 00
        walk(32'h0007_FC00, 32'h0, 32'h3333_3033, 32'h4444_44F3, 1);          // R10
        walk(32'h0007_FC00, 32'h0, 32'h3333_3033, 32'h4444_4000, 0);          // R7 fine 00
        walk(32'h0007_FC00, 32'h0, 32'h3333_3033, 32'h5555_5AA2, 2);          // R9 fine
        walk(32'h0007_FC00, 32'h0, 32'h3333_3033, 32'h6666_6CC1, 0);          // R8 fine

        // Constrained random walks (R2..R11)
        for (int i = 0; i < 400; i++)
            walk($urandom, $urandom, $urandom, $urandom, $urandom_range(0, 4));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule